// File: doc/BRIEF.md
# Captured Sample Readout Transmitter

This block drains a capture buffer toward a byte-wide serial transmitter. After a start pulse it reads a programmed number of 32-bit samples from a synchronous sample memory. It begins at the newest entry and walks toward older ones. Each sample is cut into 8-bit lanes, and lane 0 (channels 0 to 7) goes first. A lane whose channel group is switched off is left out. The byte stream has no header, trailer or separator. A host knows the transfer is over when bytes stop arriving.

Software flow control can pause and resume the stream. A pause never cuts a byte: a byte already offered to the transmitter is kept until it is taken, and the stream then holds still until a resume strobe arrives. The memory is read with a one-cycle latency, so the data of the address presented while `memRdEn` is high must be on `memData` in the next cycle. A one-cycle `done` pulse marks the end of every job, including an empty one.

Top module: `sample_readout_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `txValid`, `memRdEn` and `done` are low.
- R2: Within one sample, bytes leave in rising lane order: bits 7:0 first, then 15:8, 23:16 and 31:24.
- R3: `groupOff` bit g (g = 0 to 3) set means lane g (bits 8g+7 to 8g) of every sample is never sent. The mask is captured at the start pulse.
- R4: A job reads exactly `readCount` x 4 samples, with one memory read per sample, so `memRdEn` is never high on two cycles in a row.
- R5: The first sample read is at `lastAddr`, and each later one is at the previous address minus one, wrapping modulo 2^ADDR_W.
- R6: From the cycle after a `pauseReq` strobe, no new byte is offered. A byte offered but not yet accepted stays valid with stable data until `txReady` takes it.
- R7: After a `resumeReq` strobe the stream continues at the next pending byte, with none dropped and none repeated. A resume strobe wins over a pause strobe in the same cycle.
- R8: If `readCount` is zero or all four `groupOff` bits are set, no byte is sent and `done` is high in the cycle right after the start pulse.
- R9: `done` is high for exactly one cycle, in the cycle after the last byte is accepted (`txValid` and `txReady` both high).
- R10: A start pulse that arrives while a job is running is ignored and does not change that job's byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a job when the block is idle |
| readCount | input | CNT_W | Sample count divided by four |
| groupOff | input | DATA_W/8 | One bit per 8-channel lane; 1 suppresses that lane |
| lastAddr | input | ADDR_W | Address of the newest captured sample |
| pauseReq | input | 1 | Flow-control pause strobe |
| resumeReq | input | 1 | Flow-control resume strobe |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | DATA_W | Read data, valid one cycle after memRdEn |
| txValid | output | 1 | A byte is offered to the transmitter |
| txReady | input | 1 | The transmitter takes the offered byte |
| txData | output | 8 | Offered byte |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The end-of-job pulse is due one cycle after its cause. For a non-empty job the cause is the edge that accepts the last byte. For an empty job it is the edge that samples the start pulse. The bench stamps both events with a cycle counter, samples outputs on the falling edge, and compares the two stamps exactly. A pause strobe can let through only the one byte already on offer in the cycle it is driven. The bench therefore takes its byte-count baseline one cycle after the strobe, allows exactly one further acceptance over a long window, and compares the full stream after the resume. Byte order and lane skipping are checked after `done`, against a list the bench builds from its own memory contents.

// File: rtl/readout_pkg.sv
package readout_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture job configuration
    logic latch;       // capture memory read data
    logic advance;     // move to next enabled lane of current sample
    logic nextSample;  // step to the next older sample
  } dpCmd_t;

  // Conditions reported by the datapath
  typedef struct packed {
    logic jobEmpty;    // nothing to send for the requested job
    logic hasNext;     // another enabled lane follows the current one
    logic lastSample;  // current sample is the final one of the job
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_SEND,
    ST_FINISH
  } rdState_t;

endpackage

// File: rtl/readout_datapath.sv
module readout_datapath
  import readout_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  output dpStat_t               stat,
  input  logic [CNT_W-1:0]      readCount,
  input  logic [DATA_W/8-1:0]   groupOff,
  input  logic [ADDR_W-1:0]     lastAddr,
  input  logic [DATA_W-1:0]     memData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [7:0]            txData
);

  localparam int GROUPS = DATA_W / 8;
  localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int REM_W  = CNT_W + 2;

  logic [DATA_W-1:0] sampleQ;
  logic [GROUPS-1:0] grpEnQ;
  logic [GIDX_W-1:0] grpIdxQ;
  logic [ADDR_W-1:0] addrQ;
  logic [REM_W-1:0]  remQ;

  logic [GIDX_W-1:0] firstIdx;
  logic [GIDX_W-1:0] nextIdx;
  logic              hasNext;

  // Lane slicing of the held sample
  logic [7:0] lanes [GROUPS];
  for (genvar g = 0; g < GROUPS; g++) begin : gLane
    assign lanes[g] = sampleQ[g*8 +: 8];
  end

  // Lowest enabled lane
  always_comb begin
    firstIdx = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (grpEnQ[g]) firstIdx = GIDX_W'(g);
    end
  end

  // Lowest enabled lane above the current one
  always_comb begin
    nextIdx = grpIdxQ;
    hasNext = 1'b0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (grpEnQ[g] && (GIDX_W'(g) > grpIdxQ)) begin
        nextIdx = GIDX_W'(g);
        hasNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleQ <= '0;
      grpEnQ  <= '0;
      grpIdxQ <= '0;
      addrQ   <= '0;
      remQ    <= '0;
    end else begin
      if (cmd.load) begin
        grpEnQ <= ~groupOff;
        addrQ  <= lastAddr;
        remQ   <= {readCount, 2'b00};
      end
      if (cmd.latch) begin
        sampleQ <= memData;
        grpIdxQ <= firstIdx;
      end
      if (cmd.advance) begin
        grpIdxQ <= nextIdx;
      end
      if (cmd.nextSample) begin
        remQ  <= remQ - REM_W'(1);
        addrQ <= addrQ - ADDR_W'(1);
      end
    end
  end

  assign stat.jobEmpty   = (readCount == '0) || (&groupOff);
  assign stat.hasNext    = hasNext;
  assign stat.lastSample = (remQ == REM_W'(1));

  assign memAddr = addrQ;
  assign txData  = lanes[grpIdxQ];

endmodule

// File: rtl/readout_control.sv
module readout_control
  import readout_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    pauseReq,
  input  logic    resumeReq,
  input  logic    txReady,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    memRdEn,
  output logic    txValid,
  output logic    done
);

  rdState_t stateQ, stateD;
  logic     pausedQ;
  logic     offeredQ;
  logic     accept;

  // A byte already on offer is kept through a pause
  assign txValid = (stateQ == ST_SEND) && (!pausedQ || offeredQ);
  assign accept  = txValid && txReady;

  always_comb begin
    cmd            = '0;
    cmd.load       = (stateQ == ST_IDLE) && startPulse;
    cmd.latch      = (stateQ == ST_LATCH);
    cmd.advance    = accept && stat.hasNext;
    cmd.nextSample = accept && !stat.hasNext;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (startPulse) stateD = stat.jobEmpty ? ST_FINISH : ST_FETCH;
      ST_FETCH:  stateD = ST_LATCH;
      ST_LATCH:  stateD = ST_SEND;
      ST_SEND:   if (accept && !stat.hasNext)
                   stateD = stat.lastSample ? ST_FINISH : ST_FETCH;
      ST_FINISH: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pausedQ  <= 1'b0;
      offeredQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      offeredQ <= txValid && !txReady;
      if (resumeReq)     pausedQ <= 1'b0;
      else if (pauseReq) pausedQ <= 1'b1;
    end
  end

  assign memRdEn = (stateQ == ST_FETCH);
  assign done    = (stateQ == ST_FINISH);

endmodule

// File: rtl/sample_readout_tx.sv
module sample_readout_tx
  import readout_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [CNT_W-1:0]    readCount,
  input  logic [DATA_W/8-1:0] groupOff,
  input  logic [ADDR_W-1:0]   lastAddr,
  input  logic                pauseReq,
  input  logic                resumeReq,
  output logic                memRdEn,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W-1:0]   memData,
  output logic                txValid,
  input  logic                txReady,
  output logic [7:0]          txData,
  output logic                done
);

  dpCmd_t  cmd;
  dpStat_t stat;

  readout_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .pauseReq   (pauseReq),
    .resumeReq  (resumeReq),
    .txReady    (txReady),
    .stat       (stat),
    .cmd        (cmd),
    .memRdEn    (memRdEn),
    .txValid    (txValid),
    .done       (done)
  );

  readout_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .stat      (stat),
    .readCount (readCount),
    .groupOff  (groupOff),
    .lastAddr  (lastAddr),
    .memData   (memData),
    .memAddr   (memAddr),
    .txData    (txData)
  );

endmodule

// File: rtl/readout_checker.sv
module readout_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pauseReq,
  input logic       resumeReq,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txData,
  input logic       memRdEn,
  input logic       done
);

  // Pause state observed from the strobe ports
  logic chkPaused;
  always_ff @(posedge clk) begin
    if (!rstN)          chkPaused <= 1'b0;
    else if (resumeReq) chkPaused <= 1'b0;
    else if (pauseReq)  chkPaused <= 1'b1;
  end

  // R6: an offered byte stays put until taken
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  // R6: while paused, no fresh byte is offered
  a_r6_pause_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (chkPaused && !resumeReq && !pauseReq && !txValid) |=> !txValid);

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: at done nothing is offered or read
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!txValid && !memRdEn));

  // R4: one read per sample
  a_r4_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

endmodule

bind sample_readout_tx readout_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pauseReq  (pauseReq),
  .resumeReq (resumeReq),
  .txValid   (txValid),
  .txReady   (txReady),
  .txData    (txData),
  .memRdEn   (memRdEn),
  .done      (done)
);

// File: tb/sample_readout_tx_test.sv
module sample_readout_tx_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic [7:0] rc;
    logic [3:0] off;
    logic [9:0] last;
    logic [1:0] stall;
    logic       busy;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{rc: 8'd1, off: 4'h0, last: 10'd5,    stall: 2'd0, busy: 1'b0},
    '{rc: 8'd2, off: 4'h5, last: 10'd2,    stall: 2'd1, busy: 1'b0},
    '{rc: 8'd1, off: 4'hE, last: 10'd100,  stall: 2'd2, busy: 1'b0},
    '{rc: 8'd3, off: 4'h6, last: 10'd1023, stall: 2'd2, busy: 1'b1},
    '{rc: 8'd1, off: 4'h7, last: 10'd0,    stall: 2'd1, busy: 1'b0},
    '{rc: 8'd4, off: 4'h0, last: 10'd500,  stall: 2'd1, busy: 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              startPulse;
  logic [CNT_W-1:0]  readCount;
  logic [3:0]        groupOff;
  logic [ADDR_W-1:0] lastAddr;
  logic              pauseReq, resumeReq;
  logic              memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0]       memData;
  logic              txValid;
  logic              txReady;
  logic [7:0]        txData;
  logic              done;

  always #2.5 clk = ~clk;

  sample_readout_tx #(.DATA_W(32), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .readCount(readCount),
    .groupOff(groupOff), .lastAddr(lastAddr), .pauseReq(pauseReq),
    .resumeReq(resumeReq), .memRdEn(memRdEn), .memAddr(memAddr),
    .memData(memData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .done(done)
  );

  // Sample memory model, one-cycle read latency
  function automatic logic [31:0] wordAt(int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A0FC3E1;
  endfunction

  logic [31:0] mem [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) mem[i] = wordAt(i);
  always_ff @(posedge clk) if (memRdEn) memData <= mem[memAddr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Transmitter readiness pattern
  int stallSel = 0;
  always @(posedge clk) begin
    #1;
    case (stallSel)
      0:       txReady <= 1'b1;
      1:       txReady <= (cyc % 3) != 0;
      default: txReady <= ((cyc * 13) % 7) < 3;
    endcase
  end

  // Output monitor on the falling edge
  logic [7:0] got [256];
  int nGot = 0;
  int doneCnt = 0;
  int doneCyc = -1;
  int lastAccCyc = -1;
  int startCyc = 0;
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (txValid && txReady && nGot < 256) begin
        got[nGot] = txData;
        nGot++;
        lastAccCyc = cyc;
      end
      if (done) begin
        doneCnt++;
        doneCyc = cyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic startJob(input int rc, input logic [3:0] off, input int last);
    @(posedge clk); #1;
    readCount  = CNT_W'(rc);
    groupOff   = off;
    lastAddr   = ADDR_W'(last);
    nGot       = 0;
    doneCnt    = 0;
    startPulse = 1'b1;
    startCyc   = cyc;
    @(posedge clk); #1;
    startPulse = 1'b0;
  endtask

  task automatic waitDone();
    int w = 0;
    while (doneCnt == 0 && w < 3000) begin
      @(posedge clk);
      w++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic verify(input int rc, input logic [3:0] off, input int last,
                        input string contentReq);
    logic [7:0] exp [256];
    int nExp = 0;
    int bad = -1;
    for (int s = 0; s < rc * 4; s++) begin
      logic [31:0] w;
      w = mem[(last - s) & (DEPTH - 1)];
      for (int g = 0; g < 4; g++) begin
        if (!off[g]) begin
          exp[nExp] = w[g*8 +: 8];
          nExp++;
        end
      end
    end
    check(nGot == nExp, "R4", "byte count", nGot, nExp);
    for (int i = 0; i < nExp && i < nGot; i++) begin
      if (bad < 0 && got[i] != exp[i]) bad = i;
    end
    if (bad >= 0)
      check(1'b0, contentReq, "byte value", int'(got[bad]), int'(exp[bad]));
    else
      check(1'b1, contentReq, "byte value", 0, 0);
    check(doneCnt == 1, "R9", "done pulses", doneCnt, 1);
    if (nExp > 0)
      check(doneCyc == lastAccCyc + 1, "R9", "done cycle", doneCyc, lastAccCyc + 1);
    else
      check(doneCyc == startCyc + 1, "R8", "done cycle", doneCyc, startCyc + 1);
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startPulse = 1'b0; readCount = '0; groupOff = '0;
    lastAddr = '0; pauseReq = 1'b0; resumeReq = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!txValid && !memRdEn && !done, "R1", "outputs in reset",
          {txValid, memRdEn, done}, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(!txValid && !memRdEn && !done, "R1", "outputs after reset",
          {txValid, memRdEn, done}, 0);

    // Table of jobs: R2 R3 R5 byte content, R10 busy start
    for (int v = 0; v < NVEC; v++) begin
      stallSel = int'(VECS[v].stall);
      startJob(int'(VECS[v].rc), VECS[v].off, int'(VECS[v].last));
      if (VECS[v].busy) begin
        while (nGot < 2) @(posedge clk);
        #1;
        readCount  = CNT_W'(1);
        groupOff   = 4'h0;
        startPulse = 1'b1;
        @(posedge clk); #1;
        startPulse = 1'b0;
      end
      waitDone();
      verify(int'(VECS[v].rc), VECS[v].off, int'(VECS[v].last),
             VECS[v].busy ? "R10" : "R2 R3 R5");
    end

    // R8: all lanes disabled
    stallSel = 0;
    startJob(3, 4'hF, 17);
    waitDone();
    verify(3, 4'hF, 17, "R8");

    // R8: zero read count
    startJob(0, 4'h0, 17);
    waitDone();
    verify(0, 4'h0, 17, "R8");

    // R6 and R7: pause mid-stream, then resume
    begin
      int base;
      stallSel = 1;
      startJob(2, 4'h0, 40);
      while (nGot < 5) @(posedge clk);
      #1;
      pauseReq = 1'b1;
      @(posedge clk); #1;
      pauseReq = 1'b0;
      base = nGot;
      repeat (30) @(posedge clk);
      #1;
      check(nGot <= base + 1, "R6", "bytes while paused", nGot, base + 1);
      check(txValid == 1'b0, "R6", "txValid while paused", int'(txValid), 0);
      check(doneCnt == 0, "R6", "done while paused", doneCnt, 0);
      resumeReq = 1'b1;
      @(posedge clk); #1;
      resumeReq = 1'b0;
      waitDone();
      verify(2, 4'h0, 40, "R7");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule